// File: doc/BRIEF.md
# Asynchronous SRAM strobe controller

This block sits between a clocked host and an external asynchronous static RAM of 128K bytes. The RAM has a 17-bit address, an 8-bit shared data bus, two chip enables of opposite polarity (one active low, one active high), an active-low write enable and an active-low output enable. The host hands over one word access at a time on a valid/ready port: an address, write data and a direction flag. A read comes back as the sampled byte with a one-cycle valid pulse.

All strobe phase lengths come from nanosecond parameters and the clock period. Each one is rounded up to whole cycles. The chip is deselected between accesses, so the address only moves while the RAM ignores it. Writes are controlled by the write enable: select with write enable high, then a write-enable pulse during which the data pins are driven, then a recovery phase with the pins released. Reads hold output enable low with write enable high for the whole access phase.

The shared data pins are brought out as three signals: a driven value, a drive enable and a received value. A pad ring can then merge them. The drive enable is the only thing that turns the pad toward the RAM.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is low, mem_ce1_n, mem_we_n and mem_oe_n are 1, mem_ce2 is 0, mem_dq_oe is 0 and rsp_valid is 0.
- R2: req_ready is 1 exactly when the block is idle. A request is taken at a clock edge where req_valid and req_ready are both 1. req_ready is 0 from the next cycle until the access ends.
- R3: The RAM is selected (mem_ce1_n = 0 and mem_ce2 = 1) in every cycle of an access and deselected (mem_ce1_n = 1, mem_ce2 = 0) whenever the block is idle.
- R4: A read (req_write = 0) keeps mem_oe_n = 0 and mem_we_n = 1 for exactly RDC cycles. RDC = max(ceil(T_AA/T_CLK), ceil(T_RC/T_CLK), ceil(T_OE/T_CLK), 1), which is 9 cycles for the default parameters at 8 ns.
- R5: rsp_rdata is the value on mem_dq_in at the edge that ends the read phase. rsp_valid is 1 for exactly one cycle, the cycle after that edge.
- R6: A write (req_write = 1) runs in three phases. First, max(ceil(T_AS/T_CLK),1) select cycles with mem_we_n = 1. Next, a write-enable pulse of max(ceil(T_WP/T_CLK), ceil(T_DW/T_CLK)) cycles. Last, a recovery of max(ceil(T_WR/T_CLK), 1, remainder) cycles, where the remainder makes the total reach ceil(T_WC/T_CLK). The defaults give 1 + 7 + 1 = 9 cycles.
- R7: mem_dq_oe is 1 only while mem_we_n is 0 and mem_oe_n is 1, and mem_dq_out then carries the accepted write data.
- R8: mem_addr does not change between two consecutive cycles in which the RAM is selected.
- R9: mem_oe_n is never 0 in a cycle in which mem_dq_oe is 1 or was 1 in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 8 | Read data |
| mem_addr | output | 17 | RAM address |
| mem_ce1_n | output | 1 | Active-low chip enable |
| mem_ce2 | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Value to drive on the data pins |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_in | input | 8 | Value received from the data pins |

## Verification
The read response pulse and the acceptance of the next request can fall in the same cycle. That cycle is idle with rsp_valid high, and a new request offered in it starts at the next edge. The bench provokes this by offering the next request at the very sample where it sees rsp_valid. It runs all four orderings: read after read, write after read, read after write and write after write. It then judges that the returned byte matches a shadow copy of the memory. It also judges that the following phase still has its full length, that the data pins were released before output enable fell, and that the address did not move while the RAM was selected.

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int CLK_NS = 8,
  parameter int T_RC_NS = 70,
  parameter int T_AA_NS = 70,
  parameter int T_OE_NS = 35,
  parameter int T_WC_NS = 70,
  parameter int T_WP_NS = 50,
  parameter int T_DW_NS = 30,
  parameter int T_WR_NS = 5,
  parameter int T_AS_NS = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  function automatic int cyc(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_C  = mx(mx(cyc(T_AA_NS), cyc(T_RC_NS)), mx(cyc(T_OE_NS), 1));
  localparam int WS_C  = mx(cyc(T_AS_NS), 1);
  localparam int WP_C  = mx(mx(cyc(T_WP_NS), cyc(T_DW_NS)), 1);
  localparam int WR_C  = mx(mx(cyc(T_WR_NS), 1), cyc(T_WC_NS) - WS_C - WP_C);
  localparam int CMAX  = mx(mx(RD_C, WS_C), mx(WP_C, WR_C));
  localparam int CNT_W = $clog2(CMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_READ, S_WSEL, S_WPUL, S_WREC} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  wire               last = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          if (req_write) begin
            st  <= S_WSEL;
            cnt <= CNT_W'(WS_C - 1);
          end else begin
            st  <= S_READ;
            cnt <= CNT_W'(RD_C - 1);
          end
        end
        S_READ: if (last) begin
          rsp_rdata <= mem_dq_in;
          rsp_valid <= 1'b1;
          st        <= S_IDLE;
        end else cnt <= cnt - 1'b1;
        S_WSEL: if (last) begin
          st  <= S_WPUL;
          cnt <= CNT_W'(WP_C - 1);
        end else cnt <= cnt - 1'b1;
        S_WPUL: if (last) begin
          st  <= S_WREC;
          cnt <= CNT_W'(WR_C - 1);
        end else cnt <= cnt - 1'b1;
        S_WREC: if (last) st <= S_IDLE;
                else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (st == S_IDLE);
  assign mem_ce1_n  = (st == S_IDLE);
  assign mem_ce2    = (st != S_IDLE);
  assign mem_oe_n   = (st != S_READ);
  assign mem_we_n   = (st != S_WPUL);
  assign mem_dq_oe  = (st == S_WPUL);
  assign mem_dq_out = wdata_q;
  assign mem_addr   = addr_q;
endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk #(
  parameter int AW = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          mem_ce1_n,
  input logic          mem_ce2,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic          mem_dq_oe,
  input logic [AW-1:0] mem_addr
);
  wire sel = !mem_ce1_n && mem_ce2;

  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce1_n && !mem_ce2)); // R3
  AST_BUSY_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> sel); // R3
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sel |=> (!sel || $stable(mem_addr))); // R8
  AST_DRIVE_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && mem_oe_n && sel)); // R7
  AST_OE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe)); // R9
  AST_NO_WE_OE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n)); // R6
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R5
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready); // R2
endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(.AW(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n),
  .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe), .mem_addr(mem_addr)
);

// File: tb/sram_strobe_ctrl_tb_top.sv
module sram_strobe_ctrl_tb_top;
  localparam int CLK_NS = 8;
  function automatic int cyc(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  localparam int AA_C = cyc(70);
  localparam int RD_C = mx(mx(cyc(70), cyc(70)), mx(cyc(35), 1));
  localparam int WC_C = cyc(70);
  localparam int WS_C = mx(cyc(0), 1);
  localparam int WP_C = mx(cyc(50), cyc(30));
  localparam int WR_C = mx(mx(cyc(5), 1), WC_C - WS_C - WP_C);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  rsp_rdata, mem_dq_out;
  logic [7:0]  mem_dq_in = 'x;
  logic [16:0] mem_addr;

  always #4 clk = ~clk;

  sram_strobe_ctrl #(.CLK_NS(CLK_NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // RAM model with access delay, plus protocol monitors
  logic [7:0] mdl [int];
  logic [7:0] shadow [int];
  int rd_age = 0, mon_addr = 0, mon_drive = 0, mon_gap = 0, mon_pulse = 0;
  logic sel, wact, pw = 0, last_sel = 0, last_oe = 0, last_rsp = 0;
  logic [16:0] pa, last_addr;
  logic [7:0] pd;
  always @(negedge clk) begin
    sel  = !mem_ce1_n && mem_ce2;
    wact = sel && !mem_we_n;
    if (rst_n) begin
      if (sel && last_sel && mem_addr !== last_addr) mon_addr++;
      if (mem_dq_oe && (!mem_oe_n || mem_we_n || !sel)) mon_drive++;
      if (!mem_oe_n && (mem_dq_oe || last_oe)) mon_gap++;
      if (rsp_valid && last_rsp) mon_pulse++;
    end
    if (pw && !wact) mdl[int'(pa)] = pd;
    pw = wact; pa = mem_addr; pd = mem_dq_out;
    if (sel && !mem_oe_n && mem_we_n) rd_age++; else rd_age = 0;
    if (rd_age >= AA_C) mem_dq_in = mdl.exists(int'(mem_addr)) ? mdl[int'(mem_addr)] : 8'h00;
    else mem_dq_in = 'x;
    last_sel = sel; last_addr = mem_addr; last_oe = mem_dq_oe; last_rsp = rsp_valid;
  end

  function automatic logic [7:0] expect_rd(input logic [16:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
  endfunction

  task automatic do_write(input logic [16:0] a, input logic [7:0] d);
    int busy = 0, welow = 0;
    chk(req_ready === 1'b1, "R2 ready when idle", req_ready, 1);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    chk(!mem_ce1_n && mem_ce2 && !req_ready, "R3/R2 selected and busy", {mem_ce1_n, mem_ce2, req_ready}, 3'b010);
    while (!req_ready && busy < 100) begin
      busy++;
      if (!mem_we_n) begin
        welow++;
        if (mem_dq_oe !== 1'b1 || mem_dq_out !== d) chk(0, "R7 write data driven", mem_dq_out, d);
      end
      @(negedge clk);
    end
    chk(busy == WS_C + WP_C + WR_C, "R6 write length", busy, WS_C + WP_C + WR_C);
    chk(busy >= WC_C, "R6 write cycle minimum", busy, WC_C);
    chk(welow == WP_C, "R6 write pulse width", welow, WP_C);
    shadow[int'(a)] = d;
  endtask

  task automatic do_read(input logic [16:0] a);
    int busy = 0, oelow = 0;
    logic [7:0] e;
    e = expect_rd(a);
    chk(req_ready === 1'b1, "R2 ready when idle", req_ready, 1);
    req_valid = 1; req_write = 0; req_addr = a;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    chk(!mem_ce1_n && mem_ce2, "R3 selected during read", {mem_ce1_n, mem_ce2}, 2'b01);
    while (!rsp_valid && busy < 100) begin
      if (!req_ready) busy++;
      if (!mem_oe_n && mem_we_n) oelow++;
      @(negedge clk);
    end
    chk(busy == RD_C, "R4 read length", busy, RD_C);
    chk(oelow == RD_C, "R4 output enable window", oelow, RD_C);
    chk(rsp_rdata === e, "R5 read data", rsp_rdata, e);
    chk(req_ready === 1'b1 && mem_ce1_n && !mem_ce2, "R3 deselected at response", {req_ready, mem_ce1_n, mem_ce2}, 3'b110);
  endtask

  logic [16:0] pool [8];
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    pool[0] = 17'h00000; pool[1] = 17'h1FFFF; pool[2] = 17'h00001; pool[3] = 17'h10000;
    pool[4] = 17'h0AAAA; pool[5] = 17'h15555; pool[6] = 17'h0FFFF; pool[7] = 17'h00123;
    repeat (3) @(negedge clk);
    chk(mem_ce1_n === 1 && mem_ce2 === 0 && mem_we_n === 1 && mem_oe_n === 1,
        "R1 reset strobes", {mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n}, 4'b1011);
    chk(mem_dq_oe === 0 && rsp_valid === 0, "R1 reset bus released", {mem_dq_oe, rsp_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R2 ready after reset", req_ready, 1);
    // directed corners, back-to-back in all four orderings
    do_write(17'h00000, 8'hA5);
    do_write(17'h1FFFF, 8'h5A);
    do_read(17'h00000);
    do_read(17'h1FFFF);
    do_write(17'h00001, 8'hFF);
    do_read(17'h00001);
    do_write(17'h00001, 8'h00);
    do_read(17'h00001);
    do_read(17'h10000);
    repeat (2) @(negedge clk);
    chk(rsp_valid === 0 && mem_ce1_n === 1, "R5 pulse gone when idle", {rsp_valid, mem_ce1_n}, 2'b01);
    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [16:0] a;
      a = ($urandom % 4 == 0) ? 17'($urandom) : pool[$urandom % 8];
      if ($urandom % 2) do_write(a, 8'($urandom));
      else do_read(a);
      repeat ($urandom % 3) begin
        @(negedge clk);
        if (mem_ce1_n !== 1 || mem_ce2 !== 0) chk(0, "R3 idle deselected", {mem_ce1_n, mem_ce2}, 2'b10);
      end
    end
    chk(mon_addr == 0, "R8 address stable while selected", mon_addr, 0);
    chk(mon_drive == 0, "R7 data driven only in write pulse", mon_drive, 0);
    chk(mon_gap == 0, "R9 bus released before output enable", mon_gap, 0);
    chk(mon_pulse == 0, "R5 one-cycle response", mon_pulse, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule